// File: doc/BRIEF.md
# Implicit Return Call Tracker

This block lives inside a branch-trace encoder and decides, for each retired function return, whether the return can be dropped from the trace because a decoder can rebuild its target from the earlier call history. The core's retire stage gives it call and return strobes, the address and size of each call instruction, and the actual target of each return. The encoder gives it a synchronisation strobe and, with every return, a flag saying whether the matching call has already gone out in an earlier message. A 2-bit policy field picks how returns are predicted.

Four policies are selectable. With policy 0 nothing is inferred. Policy 1 keeps a saturating nesting count and trusts any return while calls are outstanding. Policy 2 keeps a stack of return addresses and compares only a configurable band of low address bits. Policy 3 compares the whole address. The output is a pair of per-return flags: the return is either inferable or must be reported explicitly.

The stack keeps only the most recent calls. A call made when it is full drops the oldest entry. A sync message empties both the stack and the counter.

Top module: `ret_infer_tracker`

## Requirements
- R1: With `mode_i` = 0, no return is ever inferable, and calls and returns leave the tracking state unchanged.
- R2: With `mode_i` = 1, each call adds one to a nesting count and each return takes one away. A return is inferable exactly when the count is non-zero before it, whatever its target.
- R3: The nesting count holds at 2^CNT_W-1 on further calls and holds at 0 on further returns.
- R4: With `mode_i` = 3, each call pushes `call_pc_i`+2 when `call_compressed_i` is 1, or `call_pc_i`+4 otherwise. A return is inferable only when bits ADDR_W-1..1 of `ret_target_i` equal the top entry. Bit 0 is never compared.
- R5: With `mode_i` = 2, only address bits PART_BITS..1 of the top entry and of the target are compared.
- R6: A return whose target does not match the top entry is not inferable and raises `ret_explicit_o`. The top entry is popped either way.
- R7: A return made while the stack is empty is not inferable and changes nothing.
- R8: Once DEPTH entries are held, a further call discards the oldest entry. Only the newest DEPTH calls can then be matched.
- R9: `sync_i` empties the stack and clears the count at the next edge. A return in the same cycle is not inferable, and a call in the same cycle is not recorded.
- R10: A return with `ret_call_seen_i` = 0 is not inferable, but it still pops the stack or lowers the count.
- R11: `ret_explicit_o` is 1 exactly when `ret_i` is 1 and `ret_inferable_o` is 0. Both outputs are 0 when `ret_i` is 0. Both are combinational in the return's own cycle.
- R12: After reset the stack is empty and the count is zero.
- R13: DEPTH must lie between 1 and 32; any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Policy: 0 off, 1 counter, 2 partial-address stack, 3 full-address stack |
| sync_i | input | 1 | A synchronising message is sent this cycle |
| call_i | input | 1 | A call retires this cycle |
| call_pc_i | input | ADDR_W | Address of the retiring call |
| call_compressed_i | input | 1 | The call is a 2-byte instruction |
| ret_i | input | 1 | A return retires this cycle |
| ret_target_i | input | ADDR_W | Actual target of the retiring return |
| ret_call_seen_i | input | 1 | The call matching this return was already reported |
| ret_inferable_o | output | 1 | The return may be left out of the trace |
| ret_explicit_o | output | 1 | The return must be reported explicitly |

## Verification
The assertions take for granted that a call and a return never retire in the same cycle. A dedicated input check states this, and the stack's push-plus-pop path is therefore never exercised. They also assume that `mode_i` changes only where the tracking state is irrelevant or about to be cleared. The stimulus keeps to both rules: every row drives at most one of the two strobes. Policy switches happen either on an empty stack and zero count or in the same row as a sync, so no stale entry from one policy is judged under another.

// File: rtl/rit_pkg.sv
package rit_pkg;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_COUNT   = 2'd1,
    MODE_PARTIAL = 2'd2,
    MODE_FULL    = 2'd3
  } rit_mode_e;

  localparam int unsigned RIT_MAX_DEPTH = 32;

endpackage

// File: rtl/rit_nest_counter.sv
module rit_nest_counter #(
  parameter int unsigned CNT_W = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  input  logic inc,
  input  logic dec,
  output logic nonzero
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             at_max;
  logic             at_zero;
  logic             step_up;
  logic             step_dn;

  assign at_max  = (cnt_q == CNT_MAX);
  assign at_zero = (cnt_q == '0);
  assign step_up = en && inc && !dec && !at_max;
  assign step_dn = en && dec && !inc && !at_zero;
  assign nonzero = !at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr)     cnt_q <= '0;
    else if (step_up) cnt_q <= cnt_q + 1'b1;
    else if (step_dn) cnt_q <= cnt_q - 1'b1;
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (at_max && inc && !dec && !clr) |=> at_max);

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (at_zero && dec && !inc && !clr) |=> at_zero);

  assert_sync_clears_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> at_zero);

  assert_frozen_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/rit_ret_stack.sv
module rit_ret_stack #(
  parameter int unsigned W     = 31,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] top_data,
  output logic         empty
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned OCC_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [OCC_W-1:0] OCC_FULL = OCC_W'(DEPTH);

  function automatic logic [PTR_W-1:0] ptr_fwd(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_back(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_LAST : p - 1'b1;
  endfunction

  logic [W-1:0]     slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q;
  logic [OCC_W-1:0] occ_q;
  logic [PTR_W-1:0] top_idx;
  logic             full;
  logic             do_push;
  logic             do_pop;

  assign top_idx  = ptr_back(wr_ptr_q);
  assign top_data = slot_q[top_idx];
  assign empty    = (occ_q == '0);
  assign full     = (occ_q == OCC_FULL);
  assign do_push  = push && !clr;
  assign do_pop   = pop && !clr && !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      occ_q    <= '0;
    end else if (clr) begin
      wr_ptr_q <= '0;
      occ_q    <= '0;
    end else if (do_push && !do_pop) begin
      wr_ptr_q <= ptr_fwd(wr_ptr_q);
      if (!full) occ_q <= occ_q + 1'b1;
    end else if (do_pop && !do_push) begin
      wr_ptr_q <= top_idx;
      occ_q    <= occ_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && do_pop)  slot_q[top_idx]  <= push_data;
    else if (do_push)       slot_q[wr_ptr_q] <= push_data;
  end

  assert_push_lands_on_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !clr) |=> (top_data == $past(push_data)) && !empty);

  assert_full_stays_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> full);

  assert_pop_shrinks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !clr && !empty) |=> (occ_q == $past(occ_q) - 1'b1));

  assert_empty_pop_noop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !clr) |=> empty);

  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);

endmodule

// File: rtl/rit_ret_judge.sv
module rit_ret_judge
  import rit_pkg::*;
#(
  parameter int unsigned KEY_W     = 31,
  parameter int unsigned PART_BITS = 12
) (
  input  rit_mode_e        mode,
  input  logic             ret,
  input  logic             seen,
  input  logic             sync,
  input  logic             cnt_nonzero,
  input  logic             stk_empty,
  input  logic [KEY_W-1:0] top_key,
  input  logic [KEY_W-1:0] tgt_key,
  output logic             inferable
);

  function automatic logic keys_match(input logic [KEY_W-1:0] a,
                                      input logic [KEY_W-1:0] b,
                                      input logic             low_only);
    logic [KEY_W-1:0] mask;
    mask = low_only ? KEY_W'((64'd1 << PART_BITS) - 64'd1) : {KEY_W{1'b1}};
    return ((a ^ b) & mask) == '0;
  endfunction

  logic predicted;

  always_comb begin
    unique case (mode)
      MODE_COUNT:   predicted = cnt_nonzero;
      MODE_PARTIAL: predicted = !stk_empty && keys_match(top_key, tgt_key, 1'b1);
      MODE_FULL:    predicted = !stk_empty && keys_match(top_key, tgt_key, 1'b0);
      default:      predicted = 1'b0;
    endcase
  end

  assign inferable = ret && seen && !sync && predicted;

endmodule

// File: rtl/ret_infer_tracker.sv
module ret_infer_tracker
  import rit_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned PART_BITS = 12,
  parameter int unsigned CNT_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              sync_i,
  input  logic              call_i,
  input  logic [ADDR_W-1:0] call_pc_i,
  input  logic              call_compressed_i,
  input  logic              ret_i,
  input  logic [ADDR_W-1:0] ret_target_i,
  input  logic              ret_call_seen_i,
  output logic              ret_inferable_o,
  output logic              ret_explicit_o
);

  localparam int unsigned KEY_W = ADDR_W - 1;

  generate
    if (DEPTH < 1 || DEPTH > RIT_MAX_DEPTH) begin : g_bad_depth
      $error("ret_infer_tracker: DEPTH must be 1..32 (R13)");
    end
    if (PART_BITS < 1 || PART_BITS > KEY_W) begin : g_bad_part
      $error("ret_infer_tracker: PART_BITS out of range");
    end
  endgenerate

  function automatic logic [ADDR_W-1:0] link_addr(input logic [ADDR_W-1:0] pc,
                                                  input logic              short_op);
    return pc + (short_op ? ADDR_W'(2) : ADDR_W'(4));
  endfunction

  rit_mode_e        mode;
  logic             count_mode;
  logic             stack_mode;
  logic [ADDR_W-1:0] link_full;
  logic [KEY_W-1:0] push_key;
  logic [KEY_W-1:0] tgt_key;
  logic [KEY_W-1:0] top_key;
  logic             stk_empty;
  logic             cnt_nonzero;
  logic             ev_push;
  logic             ev_pop;
  logic             unused_bit0;

  assign mode        = rit_mode_e'(mode_i);
  assign count_mode  = (mode == MODE_COUNT);
  assign stack_mode  = (mode == MODE_PARTIAL) || (mode == MODE_FULL);
  assign link_full   = link_addr(call_pc_i, call_compressed_i);
  assign push_key    = link_full[ADDR_W-1:1];
  assign tgt_key     = ret_target_i[ADDR_W-1:1];
  assign unused_bit0 = link_full[0] ^ ret_target_i[0];
  assign ev_push     = call_i && stack_mode;
  assign ev_pop      = ret_i && stack_mode;

  rit_nest_counter #(.CNT_W(CNT_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (count_mode),
    .clr     (sync_i),
    .inc     (call_i),
    .dec     (ret_i),
    .nonzero (cnt_nonzero)
  );

  rit_ret_stack #(.W(KEY_W), .DEPTH(DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (sync_i),
    .push      (ev_push),
    .push_data (push_key),
    .pop       (ev_pop),
    .top_data  (top_key),
    .empty     (stk_empty)
  );

  rit_ret_judge #(.KEY_W(KEY_W), .PART_BITS(PART_BITS)) u_judge (
    .mode        (mode),
    .ret         (ret_i),
    .seen        (ret_call_seen_i),
    .sync        (sync_i),
    .cnt_nonzero (cnt_nonzero),
    .stk_empty   (stk_empty),
    .top_key     (top_key),
    .tgt_key     (tgt_key),
    .inferable   (ret_inferable_o)
  );

  assign ret_explicit_o = ret_i && !ret_inferable_o;

  assert_input_no_call_ret_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(call_i && ret_i));

  assert_off_never_infers_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OFF) |-> !ret_inferable_o);

  assert_count_infers_only_nested_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (count_mode && ret_inferable_o) |-> cnt_nonzero);

  assert_stack_infers_only_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_mode && ret_inferable_o) |-> !stk_empty);

  assert_full_match_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FULL && ret_inferable_o) |-> (top_key == tgt_key));

  assert_unseen_call_not_inferred_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_call_seen_i |-> !ret_inferable_o);

  assert_sync_cycle_not_inferred_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |-> !ret_inferable_o);

  assert_outputs_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_i |-> (!ret_inferable_o && !ret_explicit_o));

  assert_reset_state_R12: assert property (@(posedge clk)
    $rose(rst_n) |-> (stk_empty && !cnt_nonzero));

endmodule

// File: tb/ret_infer_tracker_bench.sv
module ret_infer_tracker_bench;

  localparam int unsigned AW    = 32;
  localparam int unsigned DEPTH = 4;
  localparam int unsigned PBITS = 8;
  localparam int unsigned CW    = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode_i = '0;
  logic          sync_i = 1'b0;
  logic          call_i = 1'b0;
  logic [AW-1:0] call_pc_i = '0;
  logic          call_compressed_i = 1'b0;
  logic          ret_i = 1'b0;
  logic [AW-1:0] ret_target_i = '0;
  logic          ret_call_seen_i = 1'b0;
  logic          ret_inferable_o;
  logic          ret_explicit_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  ret_infer_tracker #(.ADDR_W(AW), .DEPTH(DEPTH), .PART_BITS(PBITS), .CNT_W(CW)) u_ret_infer_tracker (
    .clk               (clk),
    .rst_n             (rst_n),
    .mode_i            (mode_i),
    .sync_i            (sync_i),
    .call_i            (call_i),
    .call_pc_i         (call_pc_i),
    .call_compressed_i (call_compressed_i),
    .ret_i             (ret_i),
    .ret_target_i      (ret_target_i),
    .ret_call_seen_i   (ret_call_seen_i),
    .ret_inferable_o   (ret_inferable_o),
    .ret_explicit_o    (ret_explicit_o)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic        sync;
    logic        call;
    logic [31:0] pc;
    logic        cmp;
    logic        ret;
    logic [31:0] tgt;
    logic        seen;
    logic        inf;
    logic        expl;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    // mode sync call pc           cmp ret tgt          seen inf expl req
    '{2'd3, 1'b0, 1'b1, 32'h1000, 1'b0, 1'b0, 32'h0,     1'b0, 1'b0, 1'b0, 8'd4},  // R4 push 0x1004
    '{2'd3, 1'b0, 1'b1, 32'h2000, 1'b1, 1'b0, 32'h0,     1'b0, 1'b0, 1'b0, 8'd4},  // R4 push 0x2002
    '{2'd3, 1'b0, 1'b0, 32'h0,    1'b0, 1'b1, 32'h2003,  1'b1, 1'b1, 1'b0, 8'd4},  // R4 bit0 ignored
    '{2'd3, 1'b0, 1'b0, 32'h0,    1'b0, 1'b1, 32'h1008,  1'b1, 1'b0, 1'b1, 8'd6},  // R6 mismatch, pops
    '{2'd3, 1'b0, 1'b0, 32'h0,    1'b0, 1'b1, 32'h1004,  1'b1, 1'b0, 1'b1, 8'd7},  // R7 empty
    '{2'd2, 1'b0, 1'b1, 32'h5000, 1'b0, 1'b0, 32'h0,     1'b0, 1'b0, 1'b0, 8'd5},  // R5 push 0x5004
    '{2'd2, 1'b0, 1'b0, 32'h0,    1'b0, 1'b1, 32'h7004,  1'b1, 1'b1, 1'b0, 8'd5},  // R5 high bits ignored
    '{2'd2, 1'b0, 1'b1, 32'h5000, 1'b0, 1'b0, 32'h0,     1'b0, 1'b0, 1'b0, 8'd5},
    '{2'd2, 1'b0, 1'b0, 32'h0,    1'b0, 1'b1, 32'h5204,  1'b1, 1'b1, 1'b0, 8'd5},  // R5 bit 9 outside band
    '{2'd2, 1'b0, 1'b1, 32'h5000, 1'b1, 1'b0, 32'h0,     1'b0, 1'b0, 1'b0, 8'd5},  // push 0x5002
    '{2'd2, 1'b0, 1'b0, 32'h0,    1'b0, 1'b1, 32'h5102,  1'b1, 1'b0, 1'b1, 8'd5},  // R5 bit 8 inside band
    '{2'd3, 1'b0, 1'b1, 32'h3000, 1'b0, 1'b0, 32'h0,     1'b0, 1'b0, 1'b0, 8'd10},
    '{2'd3, 1'b0, 1'b0, 32'h0,    1'b0, 1'b1, 32'h3004,  1'b0, 1'b0, 1'b1, 8'd10}, // R10 unseen
    '{2'd3, 1'b0, 1'b0, 32'h0,    1'b0, 1'b1, 32'h3004,  1'b1, 1'b0, 1'b1, 8'd10}, // R10 was popped
    '{2'd0, 1'b0, 1'b1, 32'h4000, 1'b0, 1'b0, 32'h0,     1'b0, 1'b0, 1'b0, 8'd1},
    '{2'd0, 1'b0, 1'b0, 32'h0,    1'b0, 1'b1, 32'h4004,  1'b1, 1'b0, 1'b1, 8'd1},  // R1 off
    '{2'd3, 1'b0, 1'b0, 32'h0,    1'b0, 1'b1, 32'h4004,  1'b1, 1'b0, 1'b1, 8'd1},  // R1 call not kept
    '{2'd1, 1'b0, 1'b0, 32'h0,    1'b0, 1'b1, 32'h0,     1'b1, 1'b0, 1'b1, 8'd2},  // R2 count 0
    '{2'd1, 1'b0, 1'b1, 32'h800,  1'b0, 1'b0, 32'h0,     1'b0, 1'b0, 1'b0, 8'd11}, // R11 idle outputs
    '{2'd1, 1'b0, 1'b0, 32'h0,    1'b0, 1'b1, 32'hDEADBEE0, 1'b1, 1'b1, 1'b0, 8'd2}, // R2 target ignored
    '{2'd1, 1'b0, 1'b0, 32'h0,    1'b0, 1'b1, 32'h0,     1'b1, 1'b0, 1'b1, 8'd3},  // R3 at zero
    '{2'd1, 1'b0, 1'b1, 32'h800,  1'b0, 1'b0, 32'h0,     1'b0, 1'b0, 1'b0, 8'd3},
    '{2'd1, 1'b0, 1'b0, 32'h0,    1'b0, 1'b1, 32'h0,     1'b1, 1'b1, 1'b0, 8'd3},
    '{2'd1, 1'b0, 1'b0, 32'h0,    1'b0, 1'b1, 32'h0,     1'b1, 1'b0, 1'b1, 8'd3}   // R3 no wrap below 0
  };

  task automatic drive(input logic [1:0] m, input logic s, input logic c,
                       input logic [31:0] pc, input logic cm, input logic r,
                       input logic [31:0] t, input logic sn);
    mode_i = m; sync_i = s; call_i = c; call_pc_i = pc; call_compressed_i = cm;
    ret_i = r; ret_target_i = t; ret_call_seen_i = sn;
  endtask

  task automatic check(input logic ei, input logic ee, input string tag);
    n_checks++;
    if (ret_inferable_o !== ei || ret_explicit_o !== ee) begin
      n_fail++;
      $display("FAIL %s: inferable/explicit = %b/%b, expected %b/%b",
               tag, ret_inferable_o, ret_explicit_o, ei, ee);
    end
  endtask

  // one cycle: drive after falling edge, sample 1 ns later, state updates at next rise
  task automatic step(input logic [1:0] m, input logic s, input logic c,
                      input logic [31:0] pc, input logic cm, input logic r,
                      input logic [31:0] t, input logic sn,
                      input logic ei, input logic ee, input string tag);
    @(negedge clk);
    drive(m, s, c, pc, cm, r, t, sn);
    #1;
    check(ei, ee, tag);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12: reset leaves empty stack and zero count
    step(2'd3, 0, 0, 0, 0, 1, 32'h0, 1, 0, 1, "R12 stack empty after reset");
    step(2'd1, 0, 0, 0, 0, 1, 32'h0, 1, 0, 1, "R12 count zero after reset");
    step(2'd3, 0, 0, 0, 0, 0, 32'h0, 0, 0, 0, "R11 idle after reset");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i].mode, TBL[i].sync, TBL[i].call, TBL[i].pc, TBL[i].cmp,
            TBL[i].ret, TBL[i].tgt, TBL[i].seen);
      #1;
      check(TBL[i].inf, TBL[i].expl, $sformatf("R%0d row %0d", TBL[i].req, i));
    end

    // R3: counter saturates at 2^CW-1 = 7 after 9 calls
    step(2'd1, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R9 sync before saturation test");
    for (int i = 0; i < 9; i++)
      step(2'd1, 0, 1, 32'h100, 0, 0, 0, 0, 0, 0, "R3 call");
    for (int i = 0; i < 7; i++)
      step(2'd1, 0, 0, 0, 0, 1, 32'h0, 1, 1, 0, "R3 saturated count drains");
    step(2'd1, 0, 0, 0, 0, 1, 32'h0, 1, 0, 1, "R3 eighth return after saturation");

    // R9: sync clears counter, call in sync cycle ignored
    step(2'd1, 0, 1, 32'h100, 0, 0, 0, 0, 0, 0, "R9 call");
    step(2'd1, 0, 1, 32'h100, 0, 0, 0, 0, 0, 0, "R9 call");
    step(2'd1, 1, 1, 32'h100, 0, 0, 0, 0, 0, 0, "R9 sync with call");
    step(2'd1, 0, 0, 0, 0, 1, 32'h0, 1, 0, 1, "R9 count cleared by sync");

    // R9: sync clears stack, return in sync cycle not inferable
    step(2'd3, 0, 1, 32'h6000, 0, 0, 0, 0, 0, 0, "R9 push");
    step(2'd3, 0, 1, 32'h6100, 0, 0, 0, 0, 0, 0, "R9 push");
    step(2'd3, 1, 0, 0, 0, 1, 32'h6104, 1, 0, 1, "R9 return during sync");
    step(2'd3, 0, 0, 0, 0, 1, 32'h6004, 1, 0, 1, "R9 stack emptied by sync");

    // R8: DEPTH+1 pushes drop the oldest
    for (int i = 1; i <= DEPTH + 1; i++)
      step(2'd3, 0, 1, 32'(i * 256), 0, 0, 0, 0, 0, 0, "R8 push");
    for (int i = DEPTH + 1; i >= 2; i--)
      step(2'd3, 0, 0, 0, 0, 1, 32'(i * 256 + 4), 1, 1, 0, "R8 newest entries match");
    step(2'd3, 0, 0, 0, 0, 1, 32'h104, 1, 0, 1, "R8 oldest entry discarded");

    // R4: full mode compares high bits the partial band would skip
    step(2'd3, 0, 1, 32'h8000, 1, 0, 0, 0, 0, 0, "R4 push 0x8002");
    step(2'd3, 0, 0, 0, 0, 1, 32'h9002, 1, 0, 1, "R4 high bit mismatch");

    @(negedge clk);
    drive(2'd0, 0, 0, 0, 0, 0, 0, 0);
    finish_run();
  end

endmodule